// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave for a clock generator's configuration bank. It holds six writable control bytes and one fixed identification byte. The block watches the clock and data lines, which it samples against a fast system clock. It answers one 7-bit device address, 0x69. With the direction bit appended, that address is written as 0xD2 for writes and 0xD3 for reads. The only output the block drives onto the bus is a pull-down on the data line.

A write transfer carries the following bytes in order:
- the address byte;
- two header bytes, which are acknowledged and then thrown away;
- data bytes, which land in control bytes 0 to 5 in strict order.

A read transfer returns a count of seven, then bytes 0 through 6, in order. Each transfer starts from byte 0: there is no random addressing. The control bytes are driven out in parallel to the clock-gating logic. Byte 0 also shows the frequency-select pins as they were captured just after reset, and the live level of the processor-halt pin. Byte 1 shows the live level of the drive-multiplier pin.

The bus has no flow control beyond its own clocking. The slave never stretches the clock, so there is no back-pressure at the block's edge. The host paces every bit, and the slave keeps up as long as each clock phase lasts longer than its input latency.

Top module: `i2c_blk_top`

## Requirements
- R1: A START followed by address byte 0xD2 (write) or 0xD3 (read) is acknowledged: SDA is held low through the ninth SCL pulse. Any other address byte gets no acknowledge, and the rest of that transfer changes no register.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. The following data bytes are stored in control bytes 0, 1, 2, 3, 4 and 5 in that order, and each one is acknowledged.
- R3: A write may end with STOP after any complete byte. Every byte completed before the STOP is kept, and later bytes keep their previous values.
- R4: Data bytes after control byte 5 in the same write are acknowledged, and they change no register.
- R5: A read returns the count 7 first, then bytes 0 to 6. Each next byte is sent only after the host acknowledges the previous one. A byte read beyond byte 6 returns 0xFF.
- R6: Byte 6 always reads 0xFF (vendor nibble in bits 3:0, revision nibble in bits 7:4).
- R7: Byte 0 bits 2:0 hold the frequency-select pins captured in the first clock after reset. Later pin changes and writes leave these bits unchanged.
- R8: Byte 0 bit 4 follows the processor-halt pin, and byte 1 bit 7 follows the drive-multiplier pin. Writes cannot alter either bit.
- R9: After reset, the stored bits of bytes 0 to 5 read as follows: 0x08 (writable bits 7,6,5,3), 0x07 (writable bits 6:0), 0x7F (bits 6:0), 0xC7 (all bits), 0x3F (bits 5:0) and 0x00 (bits 3:0). Bits that are not writable read 0, unless they are live or captured bits.
- R10: START and STOP both reset the byte pointer, so every new write begins again at the first header byte.
- R11: The slave begins pulling SDA low only while SCL is low. It releases SDA within one clock after it detects a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND with the pull-down) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| fsel_i | input | 3 | Frequency-select pins, captured after reset |
| cpu_halt_n_i | input | 1 | Processor-halt pin level, mirrored live |
| mult_sel_i | input | 1 | Drive-multiplier pin level, mirrored live |
| ctrl_o | output | 48 | Control bytes 0..5 as read, byte k in bits 8k+7:8k |

## Verification
A line change reaches the protocol logic after two synchronizer stages, three filter cycles and one edge register. That is about seven system clocks, and the slave's SDA response follows on the next edge. The bench holds each SCL phase for twelve clocks. It samples the acknowledge bit and the read data in the middle of the SCL high phase, well after that latency. Register contents are stored on the falling SCL edge that ends the eighth bit of a byte, so the bench compares ctrl_o only after the STOP. The live pin bits are combinational, and the bench checks them one clock after it moves a pin.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

  localparam int NWR    = 6;   // writable control bytes
  localparam int NREG   = 7;   // bytes streamed on a read (control + id)
  localparam int IDX_W  = 4;   // byte pointer width, saturates at all ones
  localparam logic [7:0] ID_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_t;

  function automatic logic [7:0] reg_default(input int i);
    case (i)
      0: return 8'h08;
      1: return 8'h07;
      2: return 8'h7F;
      3: return 8'hC7;
      4: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int i);
    case (i)
      0: return 8'hE8;
      1: return 8'h7F;
      2: return 8'h7F;
      3: return 8'hFF;
      4: return 8'h3F;
      default: return 8'h0F;
    endcase
  endfunction

endpackage

// File: rtl/i2c_blk_deglitch.sv
module i2c_blk_deglitch #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (&hist_q)       dout <= 1'b1;
      else if (~|hist_q) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_blk_regs.sv
module i2c_blk_regs
  import i2c_blk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [7:0]       rd_data,
  input  logic [2:0]       fsel_i,
  input  logic             cpu_i,
  input  logic             mult_i,
  output logic [NWR*8-1:0] view_o
);
  logic [2:0] fsel_lat;
  logic       armed;

  // capture the strap pins once, in the first clock after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      fsel_lat <= 3'b000;
    end else if (!armed) begin
      armed    <= 1'b1;
      fsel_lat <= fsel_i;
    end
  end

  for (genvar g = 0; g < NWR; g++) begin : g_byte
    localparam logic [7:0] MASK = reg_wmask(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reg_default(g);
      else if (wr_en && wr_idx == IDX_W'(g)) q <= (q & ~MASK) | (wr_data & MASK);
    end
    if (g == 0) begin : g_live0
      assign view_o[g*8 +: 8] = (q & MASK) | {3'b000, cpu_i, 1'b0, fsel_lat};
    end else if (g == 1) begin : g_live1
      assign view_o[g*8 +: 8] = (q & MASK) | {mult_i, 7'h00};
    end else begin : g_plain
      assign view_o[g*8 +: 8] = q & MASK;
    end
  end

  always_comb begin
    if (rd_sel == '0)                      rd_data = 8'(NREG);
    else if (rd_sel <= IDX_W'(NWR))        rd_data = view_o[(rd_sel - 1'b1) * 8 +: 8];
    else if (rd_sel == IDX_W'(NREG))       rd_data = ID_BYTE;
    else                                   rd_data = 8'hFF;
  end
endmodule

// File: rtl/i2c_blk_link.sv
module i2c_blk_link
  import i2c_blk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  localparam logic [IDX_W-1:0] HDR = IDX_W'(2);

  bus_st_t    st;
  logic       scl_q, sda_q, addr_ph, rd_mode, host_ack;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [IDX_W-1:0] widx;

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  assign widx   = idx - HDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      addr_ph <= 1'b0; rd_mode <= 1'b0; host_ack <= 1'b0;
      bitcnt <= '0; shreg <= '0; idx <= '0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0; sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (start_c) begin
        st <= ST_RX; bitcnt <= '0; addr_ph <= 1'b1; idx <= '0; sda_pull <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; idx <= '0; sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (addr_ph) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_pull <= 1'b1; rd_mode <= shreg[0]; st <= ST_RX_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_pull <= 1'b1;
                st <= ST_RX_ACK;
                if (idx >= HDR && widx < IDX_W'(NWR)) begin
                  wr_en <= 1'b1; wr_idx <= widx; wr_data <= shreg;
                end
                if (idx != '1) idx <= idx + 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              addr_ph <= 1'b0;
              if (addr_ph && rd_mode) begin
                st <= ST_TX; shreg <= rd_data; sda_pull <= ~rd_data[7]; bitcnt <= 4'd1;
              end else begin
                st <= ST_RX; sda_pull <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0; st <= ST_TX_ACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0}; sda_pull <= ~shreg[6]; bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_f;
              if (idx != '1) idx <= idx + 1'b1;
            end else if (scl_fall) begin
              if (host_ack) begin
                st <= ST_TX; shreg <= rd_data; sda_pull <= ~rd_data[7]; bitcnt <= 4'd1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_blk_top.sv
module i2c_blk_top
  import i2c_blk_pkg::*;
#(
  parameter int         SYNC_LEN = 2,
  parameter int         FILT_LEN = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [2:0]       fsel_i,
  input  logic             cpu_halt_n_i,
  input  logic             mult_sel_i,
  output logic [NWR*8-1:0] ctrl_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] line_raw, line_f;
  logic             scl_f, sda_f;
  logic [IDX_W-1:0] idx, wr_idx;
  logic             wr_en;
  logic [7:0]       wr_data, rd_data;

  assign line_raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    i2c_blk_deglitch #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(rst_n), .din(line_raw[l]), .dout(line_f[l])
    );
  end

  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  i2c_blk_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .rd_data(rd_data), .idx(idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_pull(sda_pull_o)
  );

  i2c_blk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_sel(idx), .rd_data(rd_data),
    .fsel_i(fsel_i), .cpu_i(cpu_halt_n_i), .mult_i(mult_sel_i),
    .view_o(ctrl_o)
  );
endmodule

// File: rtl/i2c_blk_chk.sv
module i2c_blk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_f,
  input logic       sda_pull,
  input logic [2:0] strap_bits,
  input logic [7:0] byte2
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  // R11: the pull-down only starts while SCL is low
  assert_pull_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_f);

  // R11: STOP releases the data line on the next clock
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> !sda_pull);

  // R7: captured strap bits never move after capture
  assert_strap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> $stable(strap_bits));

  // R3: stored data only changes at a byte boundary, with SCL low
  assert_commit_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte2) |-> !scl_f);
endmodule

bind i2c_blk_top i2c_blk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
  .sda_pull(sda_pull_o), .strap_bits(ctrl_o[2:0]), .byte2(ctrl_o[23:16])
);

// File: tb/i2c_blk_tb.sv
module i2c_blk_top_tb_top;
  localparam int Q = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_host = 1'b1;
  logic [2:0] fsel = 3'b101;
  logic cpu = 1'b1, mult = 1'b0;
  logic sda_pull;
  logic [47:0] ctrl;
  wire sda_line = sda_host & ~sda_pull;

  int errors = 0, checks = 0, wd = 0;
  logic [7:0] st [6];
  logic [2:0] fsel_cap;

  always #4 clk = ~clk;

  i2c_blk_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .fsel_i(fsel), .cpu_halt_n_i(cpu),
    .mult_sel_i(mult), .ctrl_o(ctrl)
  );

  function automatic logic [7:0] mask_of(input int i);
    case (i) 0: return 8'hE8; 1: return 8'h7F; 2: return 8'h7F;
      3: return 8'hFF; 4: return 8'h3F; default: return 8'h0F; endcase
  endfunction

  function automatic logic [7:0] view_of(input int i);
    logic [7:0] v = st[i] & mask_of(i);
    if (i == 0) v = v | {3'b000, cpu, 1'b0, fsel_cap};
    if (i == 1) v = v | {mult, 7'h00};
    return v;
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_host = 1'b1; scl = 1'b1; wcyc(Q);
    sda_host = 1'b0; wcyc(Q);
    scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; wcyc(Q);
    scl = 1'b1; wcyc(Q);
    sda_host = 1'b1; wcyc(2 * Q);
  endtask

  // one SCL pulse; returns the line level sampled mid-high
  task automatic clk_bit(input logic b, output logic s);
    sda_host = b; wcyc(Q);
    scl = 1'b1; wcyc(Q);
    s = sda_line; wcyc(Q);
    scl = 1'b0; wcyc(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  function automatic logic [47:0] exp_ctrl();
    logic [47:0] e;
    for (int i = 0; i < 6; i++) e[i*8 +: 8] = view_of(i);
    return e;
  endfunction

  // write ndata bytes after the two header bytes; model updates the store
  task automatic do_write(input logic [7:0] d [8], input int ndata, input string req);
    logic a;
    int nack = 0;
    bus_start();
    put_byte(8'hD2, a); if (!a) nack++;
    put_byte(8'h5A, a); if (!a) nack++;
    put_byte(8'h03, a); if (!a) nack++;
    for (int i = 0; i < ndata; i++) begin
      put_byte(d[i], a); if (!a) nack++;
      if (i < 6) st[i] = (st[i] & ~mask_of(i)) | (d[i] & mask_of(i));
    end
    bus_stop();
    chk({req, " acks"}, 48'(nack), 48'd0);
  endtask

  task automatic do_read(input string req);
    logic a;
    logic [7:0] b;
    bus_start();
    put_byte(8'hD3, a);
    chk({req, " R1 read address ack"}, 48'(a), 48'd1);
    get_byte(1'b1, b);
    chk({req, " R5 count"}, 48'(b), 48'd7);
    for (int i = 0; i < 6; i++) begin
      get_byte(1'b1, b);
      chk({req, " R5 byte"}, 48'(b), 48'(view_of(i)));
    end
    get_byte(1'b1, b);
    chk({req, " R6 id byte"}, 48'(b), 48'hFF);
    get_byte(1'b0, b);
    chk({req, " R5 past end"}, 48'(b), 48'hFF);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d [8];
    for (int i = 0; i < 6; i++) st[i] = (i == 0) ? 8'h08 : (i == 1) ? 8'h07 :
      (i == 2) ? 8'h7F : (i == 3) ? 8'hC7 : (i == 4) ? 8'h3F : 8'h00;
    fsel_cap = 3'b101;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(4);
    chk("R9 reset view", ctrl, exp_ctrl());
    chk("R11 idle release", 48'(sda_pull), 48'd0);

    fsel = 3'b010; wcyc(3);
    chk("R7 strap held", 48'(ctrl[2:0]), 48'(fsel_cap));

    cpu = 1'b0; mult = 1'b1; wcyc(1);
    chk("R8 live bits", ctrl, exp_ctrl());
    cpu = 1'b1; mult = 1'b0; wcyc(1);
    chk("R8 live bits back", ctrl, exp_ctrl());

    do_read("reset");

    // R1 wrong address: no ack, no change
    bus_start();
    put_byte(8'hA4, a);
    chk("R1 foreign address nack", 48'(a), 48'd0);
    put_byte(8'h00, a); put_byte(8'h00, a); put_byte(8'h00, a);
    bus_stop();
    chk("R1 foreign write ignored", ctrl, exp_ctrl());

    // R2 sweep of full writes; R7/R8 write attempts on protected bits
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 6; i++) d[i] = 8'((k * 61 + i * 29 + 5) & 255);
      if (k == 0) begin d[0] = 8'hFF; d[1] = 8'hFF; end
      do_write(d, 6, "R2 sweep");
      chk("R2 stored bytes", ctrl, exp_ctrl());
      if (k == 0) chk("R8 write ignored", 48'({ctrl[15], ctrl[4]}), 48'({mult, cpu}));
      if (k == 0) do_read("R2 readback");
    end

    // R3 partial write keeps completed bytes only
    d[0] = 8'h20; d[1] = 8'h15;
    do_write(d, 2, "R3 partial");
    chk("R3 partial kept", ctrl, exp_ctrl());

    // R4 extra bytes acked and dropped
    for (int i = 0; i < 8; i++) d[i] = 8'(8'h11 * (i + 1));
    do_write(d, 8, "R4 overflow");
    chk("R4 extra dropped", ctrl, exp_ctrl());

    // R10 new write restarts at byte 0
    d[0] = 8'hA0;
    do_write(d, 1, "R10 restart");
    chk("R10 pointer reset", ctrl, exp_ctrl());
    do_read("R10 final");
    chk("R11 released after stop", 48'(sda_pull), 48'd0);

    summary();
  end
endmodule